// File: doc/BRIEF.md
# Dual-Mode Feedback Clock Divider

This block divides a fast input clock down to a slower output clock for the return path of a frequency-synthesis loop. It has two modes. In integer mode it divides by a whole number and gives a balanced output: the high phase is exactly half the output period, including for odd ratios, where a falling-edge register adds the missing half cycle. In fractional mode it divides by a whole number plus a 16-bit fraction weighted by 1/65536. A modulo-65536 accumulator adds the fraction once per output cycle, and each addition that wraps lengthens that cycle by one input clock.

The whole-number ratio and the mode are sampled once per output cycle, at the moment a new cycle begins. A ratio outside the legal range for the selected mode is pulled to the nearest limit, and an error flag reports it. A modulus-select output marks each output cycle that is one input clock longer than the base ratio.

Top module: `frac_fb_div`

## Requirements
- R1: While `rst` is high, and in the first cycle after each clock edge at which it was sampled high, `div_clk` and `mod_sel` are both 0; reset also sets the accumulator to 0.
- R2: With `frac_mode`=0 and a legal ratio N (2..66), successive rising edges of `div_clk` are exactly N input clock periods apart.
- R3: With `frac_mode`=0, `div_clk` is high for exactly N half-periods of the input clock in every output cycle (N/2 input cycles for even N, (N-1)/2 plus one half for odd N).
- R4: With `frac_mode`=1, every output cycle lasts N or N+1 input clocks. `mod_sel` is 1 for the whole of a cycle exactly when that cycle lasts N+1. With `frac_mode`=0, `mod_sel` stays 0.
- R5: In fractional mode with fraction F, counting output cycles k = 1, 2, ... from reset, cycle k is long exactly when floor(k*F/65536) exceeds floor((k-1)*F/65536). As a result, the first k cycles hold exactly floor(k*F/65536) long cycles.
- R6: With `frac_mode`=1, `div_clk` is high for floor(P/2) input cycles of an output cycle lasting P input cycles.
- R7: With `frac_mode`=1 and F=0, every output cycle lasts exactly N input clocks and `mod_sel` stays 0.
- R8: With `frac_mode`=0, a ratio below 2 is treated as 2 and a ratio above 66 is treated as 66. `range_err` is 1 exactly while the `ratio_int` input lies outside 2..66.
- R9: With `frac_mode`=1, a ratio below 8 is treated as 8 and a ratio above 66 is treated as 66. `range_err` is 1 exactly while the `ratio_int` input lies outside 8..66.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| frac_mode | input | 1 | 0 = integer mode, 1 = fractional mode |
| ratio_int | input | 7 | Whole-number division ratio N |
| ratio_frac | input | 16 | Fraction F, with weight F/65536 |
| div_clk | output | 1 | Divided output clock |
| mod_sel | output | 1 | High during output cycles that divide by N+1 |
| range_err | output | 1 | Ratio input outside the legal range for the selected mode |

## Verification
`range_err` depends on the inputs only, so the bench checks it a few nanoseconds after driving them. `div_clk` changes just after a clock edge: after the rising edge where a new cycle is loaded and the counter steps, and after a falling edge when a half cycle is added. The bench therefore samples it 2 ns after every rising and every falling edge, and measures periods and high times in half-period units. The first output cycle starts at the first rising edge after reset is released, and the bench counts its cycle index k from that edge. `mod_sel` is read at the first sample of each cycle and compared with the long/short value that the bench computes for that same k.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

    // Default geometry of the divider.
    localparam int RATIO_W   = 7;    // width of the whole-number ratio
    localparam int FRAC_W    = 16;   // width of the fraction / accumulator
    localparam int INT_LO    = 2;    // lowest ratio in integer mode
    localparam int FRAC_LO   = 8;    // lowest ratio in fractional mode
    localparam int RATIO_HI  = 66;   // highest ratio in either mode

    typedef enum logic {
        MODE_INT  = 1'b0,
        MODE_FRAC = 1'b1
    } div_mode_e;

    // Per-output-cycle state of the counter.
    typedef struct packed {
        logic                running;
        div_mode_e           mode;
        logic [RATIO_W-1:0]  per;
        logic [RATIO_W-1:0]  cnt;
    } cyc_state_t;

    // Pull a value into [lo, hi].
    function automatic logic [RATIO_W-1:0] clamp_ratio(
        input logic [RATIO_W-1:0] raw,
        input logic [RATIO_W-1:0] lo,
        input logic [RATIO_W-1:0] hi
    );
        if (raw < lo)      return lo;
        else if (raw > hi) return hi;
        else               return raw;
    endfunction

endpackage

// File: rtl/fbdiv_ratio_sel.sv
module fbdiv_ratio_sel
    import fbdiv_pkg::*;
#(
    parameter int LO_INT  = INT_LO,
    parameter int LO_FRAC = FRAC_LO,
    parameter int HI      = RATIO_HI
) (
    input  div_mode_e          mode,
    input  logic [RATIO_W-1:0] raw,
    output logic [RATIO_W-1:0] n_eff,
    output logic               err
);
    localparam logic [RATIO_W-1:0] LO_I = RATIO_W'(LO_INT);
    localparam logic [RATIO_W-1:0] LO_F = RATIO_W'(LO_FRAC);
    localparam logic [RATIO_W-1:0] HI_V = RATIO_W'(HI);

    logic [RATIO_W-1:0] lo_sel;

    always_comb begin
        lo_sel = (mode == MODE_FRAC) ? LO_F : LO_I;
        n_eff  = clamp_ratio(raw, lo_sel, HI_V);
        err    = (raw < lo_sel) || (raw > HI_V);
    end

    // The clamped ratio always lies inside the limits of its mode (R8, R9).
    always_comb begin
        if (!$isunknown({mode, raw})) begin
            assert_clamp_int_R8: assert (mode == MODE_FRAC || (n_eff >= LO_I && n_eff <= HI_V))
                else $error("integer ratio out of limits");
            assert_clamp_frac_R9: assert (mode == MODE_INT || (n_eff >= LO_F && n_eff <= HI_V))
                else $error("fractional ratio out of limits");
        end
    end
endmodule

// File: rtl/fbdiv_accum.sv
module fbdiv_accum
    import fbdiv_pkg::*;
#(
    parameter int FW = FRAC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,       // a new output cycle starts
    input  div_mode_e     mode,
    input  logic [FW-1:0] frac,
    output logic          carry_nxt,  // long cycle for the cycle now starting
    output logic          carry_q     // long flag of the current cycle
);
    logic [FW-1:0] acc_q;
    logic [FW:0]   sum;

    always_comb begin
        sum       = {1'b0, acc_q} + {1'b0, frac};
        carry_nxt = (mode == MODE_FRAC) ? sum[FW] : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else if (step) begin
            acc_q   <= (mode == MODE_FRAC) ? sum[FW-1:0] : '0;
            carry_q <= carry_nxt;
        end
    end

    // Integer mode never selects the long modulus (R4).
    assert_int_no_carry_R4: assert property (@(posedge clk) disable iff (rst)
        (step && mode == MODE_INT) |=> !carry_q)
        else $error("long cycle selected in integer mode");

    // A zero fraction never produces a long cycle (R7).
    assert_zero_frac_R7: assert property (@(posedge clk) disable iff (rst)
        (step && frac == '0) |=> !carry_q)
        else $error("long cycle with zero fraction");
endmodule

// File: rtl/fbdiv_counter.sv
module fbdiv_counter
    import fbdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  div_mode_e          mode,
    input  logic [RATIO_W-1:0] n_eff,
    input  logic               carry_nxt,
    output logic               step,
    output logic               running,
    output logic               hi_pos,
    output logic               odd_int    // current cycle needs the extra half
);
    cyc_state_t st_q, st_d;
    logic       last;

    always_comb begin
        last    = (st_q.cnt == st_q.per - RATIO_W'(1));
        step    = !st_q.running || last;
        st_d    = st_q;
        if (step) begin
            st_d.running = 1'b1;
            st_d.mode    = mode;
            st_d.per     = n_eff + RATIO_W'(carry_nxt);
            st_d.cnt     = '0;
        end else begin
            st_d.cnt     = st_q.cnt + RATIO_W'(1);
        end
        running = st_q.running;
        hi_pos  = st_q.running && (st_q.cnt < (st_q.per >> 1));
        odd_int = st_q.running && (st_q.mode == MODE_INT) && st_q.per[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{running: 1'b0, mode: MODE_INT, per: '0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // The cycle counter stays below the latched period (R2, R4).
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        st_q.running |-> (st_q.cnt < st_q.per))
        else $error("counter beyond period");

    // Integer-mode periods lie in 2..66 (R8).
    assert_int_period_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q.running && st_q.mode == MODE_INT) |->
            (st_q.per >= RATIO_W'(INT_LO) && st_q.per <= RATIO_W'(RATIO_HI)))
        else $error("integer period out of range");

    // Fractional periods lie in 8..67 (R4, R9).
    assert_frac_period_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q.running && st_q.mode == MODE_FRAC) |->
            (st_q.per >= RATIO_W'(FRAC_LO) && st_q.per <= RATIO_W'(RATIO_HI + 1)))
        else $error("fractional period out of range");
endmodule

// File: rtl/fbdiv_duty.sv
module fbdiv_duty (
    input  logic clk,
    input  logic rst,
    input  logic running,
    input  logic hi_pos,
    input  logic odd_int,
    output logic div_clk
);
    logic hi_neg;

    // Copy of the high phase delayed by half an input cycle.
    always_ff @(negedge clk) begin
        if (rst) hi_neg <= 1'b0;
        else     hi_neg <= hi_pos;
    end

    assign div_clk = running && (hi_pos || (odd_int && hi_neg));
endmodule

// File: rtl/frac_fb_div.sv
module frac_fb_div
    import fbdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               frac_mode,
    input  logic [RATIO_W-1:0] ratio_int,
    input  logic [FRAC_W-1:0]  ratio_frac,
    output logic               div_clk,
    output logic               mod_sel,
    output logic               range_err
);
    div_mode_e          mode;
    logic [RATIO_W-1:0] n_eff;
    logic               step, carry_nxt, running, hi_pos, odd_int;

    assign mode = frac_mode ? MODE_FRAC : MODE_INT;

    fbdiv_ratio_sel u_sel (
        .mode  (mode),
        .raw   (ratio_int),
        .n_eff (n_eff),
        .err   (range_err)
    );

    fbdiv_accum u_acc (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .mode      (mode),
        .frac      (ratio_frac),
        .carry_nxt (carry_nxt),
        .carry_q   (mod_sel)
    );

    fbdiv_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .n_eff     (n_eff),
        .carry_nxt (carry_nxt),
        .step      (step),
        .running   (running),
        .hi_pos    (hi_pos),
        .odd_int   (odd_int)
    );

    fbdiv_duty u_duty (
        .clk     (clk),
        .rst     (rst),
        .running (running),
        .hi_pos  (hi_pos),
        .odd_int (odd_int),
        .div_clk (div_clk)
    );

    // Before the first cycle is loaded the output is quiet (R1).
    assert_idle_low_R1: assert property (@(posedge clk) disable iff (rst)
        !running |-> (!div_clk && !mod_sel))
        else $error("output active while idle");
endmodule

// File: tb/frac_fb_div_bench.sv
`timescale 1ns/1ps
module frac_fb_div_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frac_mode = 1'b0;
    logic [6:0]  ratio_int = 7'd4;
    logic [15:0] ratio_frac = 16'd0;
    logic        div_clk, mod_sel, range_err;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;   // 125 MHz

    frac_fb_div u_frac_fb_div (
        .clk        (clk),
        .rst        (rst),
        .frac_mode  (frac_mode),
        .ratio_int  (ratio_int),
        .ratio_frac (ratio_frac),
        .div_clk    (div_clk),
        .mod_sel    (mod_sel),
        .range_err  (range_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int lo_lim(input bit m);
        return m ? 8 : 2;
    endfunction

    function automatic int exp_n(input bit m, input int n);
        if (n < lo_lim(m)) return lo_lim(m);
        if (n > 66) return 66;
        return n;
    endfunction

    function automatic bit exp_err(input bit m, input int n);
        return (n < lo_lim(m)) || (n > 66);
    endfunction

    function automatic bit exp_long(input bit m, input int f, input int k);
        longint a, b;
        if (!m) return 1'b0;
        a = (longint'(k) * f) >> 16;
        b = (longint'(k - 1) * f) >> 16;
        return a != b;
    endfunction

    task automatic run_cfg(input bit m, input int n, input int f, input int ncyc);
        string rq_p, rq_d, rq_e;
        int k, per_s, hi_s, longs, exp_longs, guard;
        bit prev, cur, ms;
        rq_p = m ? ((f == 0) ? "R7" : "R4") : "R2";
        rq_d = m ? "R6" : "R3";
        rq_e = m ? "R9" : "R8";
        @(negedge clk);
        rst = 1'b1;
        frac_mode = m;
        ratio_int = 7'(n);
        ratio_frac = 16'(f);
        #1;
        check(range_err == exp_err(m, n), rq_e, "range_err", range_err, exp_err(m, n));
        repeat (3) @(posedge clk);
        #2;
        check(div_clk == 1'b0 && mod_sel == 1'b0, "R1", "outputs in reset",
              {div_clk, mod_sel}, 0);
        @(negedge clk);
        rst = 1'b0;
        #2;
        prev = div_clk;
        check(prev == 1'b0, "R1", "div_clk after reset release", prev, 0);
        k = 0; per_s = 0; hi_s = 0; longs = 0; ms = 1'b0; guard = 0;
        while (k <= ncyc && guard < 200 * (ncyc + 2)) begin
            #4;
            guard++;
            cur = div_clk;
            if (cur && !prev) begin
                if (k > 0) begin
                    int p;
                    bit lg;
                    lg = exp_long(m, f, k);
                    p = exp_n(m, n) + int'(lg);
                    check(per_s == 2 * p, rq_p, $sformatf("period half-cycles k=%0d", k),
                          per_s, 2 * p);
                    check(hi_s == (m ? 2 * (p / 2) : p), rq_d,
                          $sformatf("high half-cycles k=%0d", k), hi_s, m ? 2 * (p / 2) : p);
                    check(ms == lg, m ? "R5" : "R4", $sformatf("mod_sel k=%0d", k), ms, lg);
                    longs += int'(ms);
                end
                k++;
                per_s = 1;
                hi_s = 1;
                ms = mod_sel;
            end else begin
                per_s++;
                hi_s += int'(cur);
            end
            prev = cur;
        end
        check(k > ncyc, rq_p, "output cycles seen", k - 1, ncyc);
        exp_longs = m ? int'((longint'(ncyc) * f) >> 16) : 0;
        check(longs == exp_longs, "R5", "long cycle count", longs, exp_longs);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2718);
        // Directed corners
        run_cfg(1'b0, 2, 0, 6);          // R2 smallest integer ratio
        run_cfg(1'b0, 7, 0, 6);          // R3 odd ratio, balanced duty
        run_cfg(1'b0, 66, 0, 3);         // R2 largest ratio
        run_cfg(1'b0, 0, 0, 4);          // R8 below range -> 2
        run_cfg(1'b0, 1, 0, 4);          // R8 below range -> 2
        run_cfg(1'b0, 100, 0, 3);        // R8 above range -> 66
        run_cfg(1'b1, 3, 16'h4000, 8);   // R9 below range -> 8
        run_cfg(1'b1, 127, 16'hC000, 6); // R9 above range -> 66
        run_cfg(1'b1, 9, 0, 8);          // R7 zero fraction
        run_cfg(1'b1, 10, 16'h8000, 16); // R4 alternating
        run_cfg(1'b1, 8, 16'hFFFF, 12);  // R4 nearly every cycle long
        run_cfg(1'b1, 11, 16'h1000, 40); // R5 one long per sixteen
        // Constrained random
        for (int i = 0; i < 10; i++) begin
            bit m;
            int n, f;
            m = 1'(($urandom() >> 3) & 1);
            n = m ? 8 + int'($urandom() % 59) : 2 + int'($urandom() % 65);
            f = int'($urandom() & 32'hFFFF);
            run_cfg(m, n, f, 12);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule